// File: doc/BRIEF.md
# SMBus Register Target with Alert Response

This block is the bus-facing half of a register-controlled device. It listens on an open-drain two-wire SMBus and gives a host access to a bank of 64 eight-bit registers. The registers themselves sit outside the block; it drives their address, write data and write strobe, and takes their read data back combinationally. Every transfer starts from an internal register pointer. A command byte loads that pointer, and the pointer then steps forward through the bank during a burst. It stops at the last register and does not wrap to zero.

The block also answers the bus alert-response address while its device raises an alert. It returns its own address and drops out of that reply as soon as another device with a lower address wins the wired-AND bus. SCL and SDA each pass through a two-flop synchroniser before the block detects edges on them. The block pulls SDA low through an enable output and never drives it high.

The controller states are IDLE, ADDR, ADDR_ACK, CMD, CMD_ACK, WDATA, WDATA_ACK, RDATA, RDATA_ACK, ARA_TX and IGNORE.
- A START enters ADDR from any state. A STOP returns to IDLE from any state.
- After ADDR has taken in eight bits, the block goes to ADDR_ACK if it recognises the address and to IGNORE if it does not.
- On the SCL fall that ends ADDR_ACK, the block goes to ARA_TX for an alert-response read, to RDATA for any other read, and to CMD for a write.
- CMD goes to CMD_ACK after eight bits. CMD_ACK goes to WDATA, and WDATA and WDATA_ACK then alternate.
- RDATA goes to RDATA_ACK after eight bits. From RDATA_ACK the block returns to RDATA if the master acknowledged and goes to IGNORE if the master did not.
- ARA_TX goes to IGNORE when the block loses arbitration or when its byte is complete.

Top module: `smb_reg_target`

## Requirements
- R1: The target address is 0x18 OR'ed with the two address-select inputs (0x18 to 0x1B). The block captures it on the first clock after reset is released, and later changes on the select inputs have no effect until the next reset.
- R2: Write byte: the master sends the target address with R/W=0, then a command byte, then a data byte. The block ACKs all three and writes the data to the register given by bits 5:0 of the command byte. Bits 7:6 of the command byte are ignored.
- R3: A command byte on its own loads the pointer (send byte). A following read addressed to the target (receive byte) returns the register the pointer selects.
- R4: Read byte: command byte, then a repeated START and a read. The block returns the register named by the command byte.
- R5: During a burst write the pointer advances by one after each data byte. Once the byte for register 0x3F has been written, the block still ACKs further data bytes but writes none of them.
- R6: During a burst read the pointer advances by one after each byte. Once register 0x3F has been sent, every further byte is 0x00 until STOP.
- R7: While alert_i is high, a read addressed to 0001100 is ACKed and answered with one byte: the target address in bits 7:1 and 0 in bit 0. While alert_i is low, that address is not ACKed.
- R8: In the alert response, if SDA reads low in a bit where the block released it, the block stops driving SDA for the rest of the byte.
- R9: stat_clr pulses for exactly one clock after a byte read from register STAT_ADDR (default 0x02) has been fully shifted out. Reads from any other register produce no pulse.
- R10: Bytes are sent MSB first. The block changes sda_oe only while SCL is low.
- R11: A transfer to any other address gets no ACK and causes no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level read from the bus |
| sda_i | input | 1 | SDA level read from the bus |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| addr_sel | input | 2 | Target address select, captured after reset |
| alert_i | input | 1 | Alert pending from the device |
| reg_addr | output | AW (6) | Register pointer presented to the register bank |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | One-clock write strobe |
| reg_rdata | input | 8 | Read data for reg_addr |
| stat_clr | output | 1 | Clear-on-read strobe for the status register |

## Verification
The hardest case to reach from the ports is losing arbitration partway through the alert-response byte. The bench models a second device on the wired-AND SDA line. That device has a lower address and drives its own response bits in step with the master's clock. The address pair is chosen so the block loses on a bit where it releases SDA, and on the very next bit it would pull SDA low where the rival releases it. The byte the master receives therefore shows whether the block really stopped driving. The saturation cases at register 0x3F are reached with bursts that start at 0x3E.

// File: rtl/smb_pkg.sv
package smb_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_ARA_TX,
        ST_IGNORE
    } smb_state_e;

    localparam logic [6:0] ARA_ADDR = 7'b0001100;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s,
    output logic line_q
);
    logic meta;

    // Bus idles high, so reset to 1 to avoid false edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta   <= 1'b1;
            line_s <= 1'b1;
            line_q <= 1'b1;
        end else begin
            meta   <= line_i;
            line_s <= meta;
            line_q <= line_s;
        end
    end
endmodule

// File: rtl/smb_addr_latch.sv
module smb_addr_latch #(
    parameter logic [6:0] BASE_ADDR = 7'h18,
    parameter int         SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    output logic [6:0]       addr_o,
    output logic             valid_o
);
    // Capture once on the first clock after reset release.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o  <= BASE_ADDR;
            valid_o <= 1'b0;
        end else if (!valid_o) begin
            addr_o  <= BASE_ADDR | 7'(sel_i);
            valid_o <= 1'b1;
        end
    end
endmodule

// File: rtl/smb_reg_target.sv
module smb_reg_target
    import smb_pkg::*;
#(
    parameter int         REG_COUNT = 64,
    parameter int         AW        = $clog2(REG_COUNT),
    parameter logic [6:0] BASE_ADDR = 7'h18,
    parameter logic [AW-1:0] STAT_ADDR = AW'(2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic [1:0]    addr_sel,
    input  logic          alert_i,
    output logic [AW-1:0] reg_addr,
    output logic [7:0]    reg_wdata,
    output logic          reg_we,
    input  logic [7:0]    reg_rdata,
    output logic          stat_clr
);
    localparam logic [AW-1:0] LAST = AW'(REG_COUNT - 1);

    logic [1:0] raw, syn, dly;
    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        smb_line_sync u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw[g]),
            .line_s (syn[g]),
            .line_q (dly[g])
        );
    end

    logic scl_s, scl_q, sda_s, sda_q;
    assign {scl_s, sda_s} = syn;
    assign {scl_q, sda_q} = dly;

    logic scl_rise, scl_fall, start, stop;
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start    = scl_s & scl_q & sda_q & ~sda_s;
    assign stop     = scl_s & scl_q & ~sda_q & sda_s;

    logic [6:0] dev_addr;
    logic       addr_ok;

    smb_addr_latch #(.BASE_ADDR(BASE_ADDR), .SEL_W(2)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (addr_sel),
        .addr_o  (dev_addr),
        .valid_o (addr_ok)
    );

    smb_state_e st, nxt;
    logic [7:0]    sh, tx;
    logic [2:0]    cnt;
    logic          done, rw, ara, m_ack, past_end;
    logic [AW-1:0] ptr;

    logic byte_fall, addr_hit, ara_hit, lost, shift_st, tx_st;
    assign byte_fall = scl_fall & done;
    assign addr_hit  = addr_ok && (sh[7:1] == dev_addr);
    assign ara_hit   = (sh[7:1] == ARA_ADDR) && sh[0] && alert_i;
    assign tx_st     = (st == ST_RDATA) || (st == ST_ARA_TX);
    assign shift_st  = tx_st || (st == ST_ADDR) || (st == ST_CMD) || (st == ST_WDATA);
    assign lost      = (st == ST_ARA_TX) && scl_rise && tx[7] && !sda_s;

    // Next-state logic
    always_comb begin
        nxt = st;
        if (start) begin
            nxt = ST_ADDR;
        end else if (stop) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ADDR:      if (byte_fall) nxt = (addr_hit || ara_hit) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall) nxt = ara ? ST_ARA_TX : (rw ? ST_RDATA : ST_CMD);
                ST_CMD:       if (byte_fall) nxt = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (byte_fall) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:     if (byte_fall) nxt = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall) nxt = m_ack ? ST_RDATA : ST_IGNORE;
                ST_ARA_TX:    if (lost || byte_fall) nxt = ST_IGNORE;
                ST_IGNORE:    nxt = ST_IGNORE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Datapath: shifters, bit counter, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0; tx <= '0; cnt <= '0; done <= 1'b0;
            rw <= 1'b0; ara <= 1'b0; m_ack <= 1'b0;
            ptr <= '0; past_end <= 1'b0;
        end else if (start || stop) begin
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            if (scl_rise && shift_st) begin
                sh  <= {sh[6:0], sda_s};
                cnt <= cnt + 3'd1;
                if (cnt == 3'd7) done <= 1'b1;
            end
            if (scl_rise && st == ST_RDATA_ACK) m_ack <= ~sda_s;
            if (byte_fall) begin
                cnt  <= '0;
                done <= 1'b0;
                if (st == ST_ADDR) begin
                    rw  <= sh[0];
                    ara <= ara_hit;
                end
                if (st == ST_CMD) begin
                    ptr      <= sh[AW-1:0];
                    past_end <= 1'b0;
                end
                if ((st == ST_WDATA || st == ST_RDATA) && !past_end) begin
                    if (ptr == LAST) past_end <= 1'b1;
                    else             ptr <= ptr + AW'(1);
                end
            end else if (scl_fall && tx_st) begin
                tx <= {tx[6:0], 1'b0};
            end
            if (scl_fall && ((st == ST_ADDR_ACK && rw && !ara) ||
                             (st == ST_RDATA_ACK && m_ack)))
                tx <= past_end ? 8'h00 : reg_rdata;
            if (scl_fall && st == ST_ADDR_ACK && ara)
                tx <= {dev_addr, 1'b0};
        end
    end

    // Outputs
    always_comb begin
        sda_oe    = 1'b0;
        reg_addr  = ptr;
        reg_wdata = sh;
        reg_we    = (st == ST_WDATA) && byte_fall && !past_end;
        stat_clr  = (st == ST_RDATA) && byte_fall && !past_end && (ptr == STAT_ADDR);
        unique case (st)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA, ST_ARA_TX:                   sda_oe = ~tx[7];
            default:                               sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/smb_reg_target_chk.sv
module smb_reg_target_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          sda_oe,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic          stat_clr,
    input logic [6:0]    dev_addr,
    input logic          addr_ok
);
    localparam logic [AW-1:0] TOP = '1;

    // R1: captured address never moves after capture
    a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ok |=> $stable(dev_addr));

    // R5: every accepted write advances the pointer or leaves it at the top
    a_r5_write_advance: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (($past(reg_addr) != TOP) && (reg_addr == $past(reg_addr) + AW'(1))) ||
                   (($past(reg_addr) == TOP) && (reg_addr == TOP)));

    // R9: clear strobe lasts a single clock
    a_r9_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> !stat_clr);

    // R10: drive enable changes only while synchronised SCL is low
    a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);
endmodule

bind smb_reg_target smb_reg_target_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .stat_clr (stat_clr),
    .dev_addr (dev_addr),
    .addr_ok  (addr_ok)
);

// File: tb/smb_reg_target_tb_top.sv
module smb_reg_target_tb_top;
    localparam int Q = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_low = 1'b0, o_low = 1'b0;
    logic [1:0] addr_sel = 2'd2;
    logic       alert = 1'b0;
    logic       sda_oe, reg_we, stat_clr;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] rf [64];
    wire        sda_bus = ~(sda_oe | m_low | o_low);

    int checks = 0, fails = 0, clr_cnt = 0, viol = 0;
    bit finished = 0;

    smb_reg_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .alert_i(alert), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata), .stat_clr(stat_clr)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    assign reg_rdata = rf[reg_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) rf[i] <= init_val(i);
        end else if (reg_we) begin
            rf[reg_addr] <= reg_wdata;
        end
    end

    always @(posedge clk) if (rst_n && stat_clr) clr_cnt++;

    logic oe_p = 1'b0, scl_p = 1'b1;
    always @(posedge clk) begin
        if (rst_n && m_scl && scl_p && (sda_oe != oe_p)) viol++;
        oe_p  <= sda_oe;
        scl_p <= m_scl;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic w;
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start;
        m_low = 0; m_scl = 1; w(); m_low = 1; w(); m_scl = 0; w();
    endtask

    task automatic m_rstart;
        m_low = 0; w(); m_scl = 1; w(); m_low = 1; w(); m_scl = 0; w();
    endtask

    task automatic m_stop;
        m_low = 1; w(); m_scl = 1; w(); m_low = 0; w();
    endtask

    task automatic m_wbit(input bit b);
        m_low = ~b; w(); m_scl = 1; w(); w(); m_scl = 0;
    endtask

    task automatic m_rbit(output bit b);
        m_low = 0; w(); m_scl = 1; w(); b = sda_bus; w(); m_scl = 0;
    endtask

    task automatic m_wbyte(input logic [7:0] d, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) m_wbit(d[i]);
        m_rbit(b);
        ack = ~b;
    endtask

    task automatic m_rbyte(output logic [7:0] d, input bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) begin m_rbit(b); d[i] = b; end
        m_wbit(~ack);
    endtask

    task automatic do_reset(input logic [1:0] sel);
        addr_sel = sel; rst_n = 0; m_scl = 1; m_low = 0; o_low = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);
    endtask

    task automatic write_regs(input logic [6:0] a, input logic [7:0] cmd,
                              input logic [7:0] d[], output bit all_ack);
        bit ack;
        all_ack = 1;
        m_start();
        m_wbyte({a, 1'b0}, ack); all_ack &= ack;
        m_wbyte(cmd, ack);       all_ack &= ack;
        foreach (d[i]) begin m_wbyte(d[i], ack); all_ack &= ack; end
        m_stop();
    endtask

    task automatic read_regs(input logic [6:0] a, input logic [7:0] cmd, input int n,
                             output logic [7:0] d[]);
        bit ack;
        d = new[n];
        m_start();
        m_wbyte({a, 1'b0}, ack);
        m_wbyte(cmd, ack);
        m_rstart();
        m_wbyte({a, 1'b1}, ack);
        for (int i = 0; i < n; i++) m_rbyte(d[i], i != n - 1);
        m_stop();
    endtask

    task automatic t_reset;
        chk(sda_oe == 0, "R10 reset oe", sda_oe, 0);
        chk(stat_clr == 0 && reg_we == 0, "R9 reset strobes", stat_clr, 0);
    endtask

    task automatic t_write_read_byte;
        bit ok;
        logic [7:0] d[];
        write_regs(7'h1A, 8'hC5, '{8'hA5}, ok);
        chk(ok, "R2 write acks", ok, 1);
        chk(rf[5] == 8'hA5, "R2 reg written (cmd bits 7:6 ignored)", rf[5], 8'hA5);
        read_regs(7'h1A, 8'h05, 1, d);
        chk(d[0] == 8'hA5, "R4 read byte", d[0], 8'hA5);
        read_regs(7'h1A, 8'h09, 1, d);
        chk(d[0] == init_val(9), "R10 msb-first read", d[0], init_val(9));
    endtask

    task automatic t_send_receive;
        bit ack;
        logic [7:0] d;
        m_start(); m_wbyte({7'h1A, 1'b0}, ack); m_wbyte(8'h10, ack); m_stop();
        m_start(); m_wbyte({7'h1A, 1'b1}, ack); m_rbyte(d, 0); m_stop();
        chk(ack && d == init_val(16), "R3 receive byte", d, init_val(16));
    endtask

    task automatic t_burst_write;
        bit ok;
        logic [7:0] r0;
        r0 = rf[0];
        write_regs(7'h1A, 8'h3E, '{8'h11, 8'h22, 8'h33}, ok);
        chk(ok, "R5 extra byte acked", ok, 1);
        chk(rf[62] == 8'h11 && rf[63] == 8'h22, "R5 burst write", rf[63], 8'h22);
        chk(rf[0] == r0, "R5 no wrap write", rf[0], r0);
    endtask

    task automatic t_burst_read;
        logic [7:0] d[];
        read_regs(7'h1A, 8'h3E, 4, d);
        chk(d[0] == 8'h11 && d[1] == 8'h22, "R6 burst read", d[1], 8'h22);
        chk(d[2] == 8'h00 && d[3] == 8'h00, "R6 zero past end", d[2], 0);
    endtask

    task automatic t_status_clear;
        logic [7:0] d[];
        int c0;
        c0 = clr_cnt; read_regs(7'h1A, 8'h02, 1, d);
        chk(clr_cnt - c0 == 1, "R9 clear on status read", clr_cnt - c0, 1);
        c0 = clr_cnt; read_regs(7'h1A, 8'h03, 1, d);
        chk(clr_cnt - c0 == 0, "R9 no clear other reg", clr_cnt - c0, 0);
        c0 = clr_cnt; read_regs(7'h1A, 8'h01, 3, d);
        chk(clr_cnt - c0 == 1 && d[1] == init_val(2), "R9 clear in burst", clr_cnt - c0, 1);
    endtask

    task automatic t_ara(input bit rival);
        bit ack, b;
        logic [7:0] d;
        logic [7:0] rv;
        rv = {7'h19, 1'b0};
        alert = 1;
        m_start();
        m_wbyte({7'b0001100, 1'b1}, ack);
        for (int i = 7; i >= 0; i--) begin
            o_low = rival & ~rv[i];
            m_rbit(b); d[i] = b;
        end
        o_low = 0;
        m_wbit(1);
        m_stop();
        alert = 0;
        if (rival) chk(ack && d == 8'h32, "R8 arbitration lost", d, 8'h32);
        else       chk(ack && d == 8'h34, "R7 alert response", d, 8'h34);
    endtask

    task automatic t_ara_idle;
        bit ack;
        m_start(); m_wbyte({7'b0001100, 1'b1}, ack); m_stop();
        chk(!ack, "R7 no reply without alert", ack, 0);
    endtask

    task automatic t_foreign;
        bit ok;
        logic [7:0] d[];
        write_regs(7'h18, 8'h07, '{8'h99}, ok);
        read_regs(7'h1A, 8'h07, 1, d);
        chk(!ok && d[0] == init_val(7), "R11 foreign address", d[0], init_val(7));
    endtask

    task automatic t_addr_sel;
        bit ack;
        addr_sel = 2'd0;
        m_start(); m_wbyte({7'h1A, 1'b0}, ack); m_stop();
        chk(ack, "R1 old address kept", ack, 1);
        m_start(); m_wbyte({7'h18, 1'b0}, ack); m_stop();
        chk(!ack, "R1 new select ignored", ack, 0);
        do_reset(2'd1);
        m_start(); m_wbyte({7'h19, 1'b0}, ack); m_stop();
        chk(ack, "R1 address after reset", ack, 1);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        do_reset(2'd2);
        t_reset();
        t_write_read_byte();
        t_send_receive();
        t_burst_write();
        t_burst_read();
        t_status_clear();
        t_ara(0);
        t_ara(1);
        t_ara_idle();
        t_foreign();
        t_addr_sel();
        chk(viol == 0, "R10 oe change with SCL high", viol, 0);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule